// File: doc/BRIEF.md
# In-Order Destination Scoreboard with Poison Drain

This block records the destination registers of instructions that have left the register-fetch stage of a pipelined core and have not yet retired. Register fetch presents two source register numbers every cycle. The block raises a stall flag for each source that names a destination still pending, so that a read-after-write hazard holds the instruction back.

Entries are kept in a circular queue. One is appended when an instruction passes register fetch. The oldest one is dropped when writeback pulses the remove strobe. There is no other way to drop an entry.

An instruction found to be on the wrong path is not taken out where it is discovered. It travels on with a poison mark. At writeback it still pulses remove, which frees its entry, but it makes no register or memory write. Because of this, entries always leave in the order they arrived. The poison mark itself is handled by the surrounding pipeline.

Top module: `dest_scoreboard`

## Requirements
- R1: After reset the queue is empty: `full` is low and no source register causes a stall.
- R2: Once an instruction with a destination register is accepted, a source equal to that register raises the stall flag of the port carrying it, on either search port. The combined `stall` is the OR of the two port flags.
- R3: An entry inserted with `ins_has_dst` low never causes a match, but it still occupies a queue slot.
- R4: A source equal to register 0 never raises a stall, even if a pending entry names register 0.
- R5: `full` is high exactly when DEPTH entries are held (DEPTH = 4 by default). An insert presented while `full` is high is dropped, and its register never matches.
- R6: A remove strobe drops the oldest held entry. Younger entries, including ones with the same destination, keep stalling until their own removal.
- R7: A remove strobe on an empty queue is ignored. Afterwards exactly DEPTH inserts are needed to raise `full`.
- R8: Search results reflect the entries held at the start of the cycle. An entry being removed in a cycle still stalls a matching source during that same cycle.
- R9: When the queue is neither empty nor full, an insert and a remove in the same cycle both take effect. The occupancy is unchanged, the oldest entry leaves and the new one is held.
- R10: Entries stay held for any number of idle cycles until they are removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction leaving register fetch: append an entry |
| ins_has_dst | input | 1 | The inserted instruction writes a destination register |
| ins_dst | input | REG_W | Destination register number of the inserted instruction |
| src_a | input | REG_W | First source register to search |
| src_b | input | REG_W | Second source register to search |
| remove | input | 1 | Writeback retire strobe (poisoned or not): drop the oldest entry |
| stall_a | output | 1 | `src_a` matches a pending destination |
| stall_b | output | 1 | `src_b` matches a pending destination |
| stall | output | 1 | Either source matches |
| full | output | 1 | DEPTH entries held; inserts are refused |

## Verification
Insertion and removal can fall in the same cycle, and so can removal and a search. The bench provokes the first on a partly filled queue and on a full one. It judges the result from which registers still stall afterwards and from when `full` rises. For the second, it holds remove high while probing the departing register. The stall is sampled before the clock edge, where it must still be high, and again after the edge, where it must have dropped.

// File: rtl/dest_scoreboard.sv
module dest_scoreboard #(
  parameter int DEPTH = 4,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             ins_has_dst,
  input  logic [REG_W-1:0] ins_dst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             remove,
  output logic             stall_a,
  output logic             stall_b,
  output logic             stall,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [REG_W-1:0] dst_q [DEPTH];
  logic [DEPTH-1:0] has_q, live_q, hit_a, hit_b;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take_ins, take_rem;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign take_ins = ins_valid && !full;
  assign take_rem = remove && (cnt_q != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign hit_a[i] = live_q[i] && has_q[i] && (dst_q[i] == src_a);
    assign hit_b[i] = live_q[i] && has_q[i] && (dst_q[i] == src_b);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[i] <= 1'b0;
        has_q[i]  <= 1'b0;
        dst_q[i]  <= '0;
      end else begin
        if (take_rem && head_q == PTR_W'(i)) live_q[i] <= 1'b0;
        if (take_ins && tail_q == PTR_W'(i)) begin
          live_q[i] <= 1'b1;
          has_q[i]  <= ins_has_dst;
          dst_q[i]  <= ins_dst;
        end
      end
    end
  end

  assign stall_a = (src_a != '0) && (|hit_a);
  assign stall_b = (src_b != '0) && (|hit_b);
  assign stall   = stall_a || stall_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (take_ins) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
      if (take_rem) head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
      case ({take_ins, take_rem})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R5
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(live_q) == 32'(cnt_q));

  // R5
  refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && full && !remove) |=> full);

  // R7
  empty_remove_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remove && !ins_valid && cnt_q == '0) |=> (cnt_q == '0));

  // R9
  swap_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && remove && !full && cnt_q != '0) |=> $stable(cnt_q));

  // R1
  empty_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !stall);
endmodule

// File: tb/dest_scoreboard_test.sv
module dest_scoreboard_test;
  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_has_dst = 0, remove = 0;
  logic [4:0] ins_dst = 0, src_a = 0, src_b = 0;
  logic stall_a, stall_b, stall, full;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dest_scoreboard #(.DEPTH(4), .REG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_has_dst(ins_has_dst),
    .ins_dst(ins_dst), .src_a(src_a), .src_b(src_b), .remove(remove),
    .stall_a(stall_a), .stall_b(stall_b), .stall(stall), .full(full));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; ins_valid = 0; remove = 0; src_a = 0; src_b = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic step(input bit iv, input bit ih, input int d, input bit rm);
    ins_valid = iv; ins_has_dst = ih; ins_dst = 5'(d); remove = rm;
    @(posedge clk); #1;
    ins_valid = 0; remove = 0;
  endtask

  task automatic probe(input int a, input int b);
    src_a = 5'(a); src_b = 5'(b); #1;
  endtask

  task automatic t_reset();
    do_reset();
    probe(3, 17);
    check(!full, "R1 full", full, 0);
    check(!stall, "R1 stall", stall, 0);
  endtask

  task automatic t_match();
    do_reset();
    step(1, 1, 9, 0);
    probe(9, 2);
    check(stall_a && !stall_b && stall, "R2 port a", {stall_a, stall_b, stall}, 3'b101);
    probe(4, 9);
    check(!stall_a && stall_b && stall, "R2 port b", {stall_a, stall_b, stall}, 3'b011);
    probe(4, 5);
    check(!stall, "R2 no match", stall, 0);
  endtask

  task automatic t_nodst_zero();
    do_reset();
    step(1, 0, 6, 0);
    step(1, 1, 0, 0);
    probe(6, 0);
    check(!stall, "R3/R4 no match", {stall_a, stall_b}, 0);
    step(1, 1, 11, 0);
    step(1, 1, 12, 0);
    check(full, "R3 slot held", full, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 1; i <= 4; i++) begin
      check(!full, "R5 not yet full", full, 0);
      step(1, 1, i, 0);
    end
    check(full, "R5 full at depth", full, 1);
    step(1, 1, 20, 0);
    probe(20, 4);
    check(!stall_a && stall_b, "R5 refused insert", {stall_a, stall_b}, 2'b01);
    step(1, 1, 21, 1);
    probe(21, 1);
    check(!stall_a && !stall_b && !full, "R5 full swap refused", {stall_a, stall_b, full}, 0);
  endtask

  task automatic t_order();
    do_reset();
    step(1, 1, 8, 0);
    step(1, 1, 13, 0);
    step(1, 1, 8, 0);
    step(0, 0, 0, 1);
    probe(8, 13);
    check(stall_a, "R6 duplicate kept", stall_a, 1);
    check(stall_b, "R6 younger kept", stall_b, 1);
    step(0, 0, 0, 1);
    probe(8, 13);
    check(stall_a && !stall_b, "R6 oldest first", {stall_a, stall_b}, 2'b10);
    step(0, 0, 0, 1);
    probe(8, 13);
    check(!stall, "R6 drained", stall, 0);
  endtask

  task automatic t_empty_remove();
    do_reset();
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 14, 0);
    check(!full, "R7 three not full", full, 1'b0);
    step(1, 1, 15, 0);
    check(full, "R7 four full", full, 1);
  endtask

  task automatic t_same_cycle_search();
    do_reset();
    step(1, 1, 7, 0);
    src_a = 7; src_b = 0; remove = 1; #1;
    check(stall_a, "R8 stall during remove", stall_a, 1);
    @(posedge clk); #1;
    remove = 0; #1;
    check(!stall_a, "R8 gone after remove", stall_a, 0);
  endtask

  task automatic t_swap();
    do_reset();
    step(1, 1, 1, 0);
    step(1, 1, 2, 0);
    step(1, 1, 3, 0);
    step(1, 1, 22, 1);
    probe(1, 22);
    check(!stall_a && stall_b, "R9 swap", {stall_a, stall_b}, 2'b01);
    check(!full, "R9 count kept", full, 0);
    step(1, 1, 23, 0);
    check(full, "R9 one more fills", full, 1);
  endtask

  task automatic t_hold();
    do_reset();
    step(1, 1, 30, 0);
    repeat (50) @(posedge clk);
    probe(0, 30);
    check(stall_b, "R10 held", stall_b, 1);
  endtask

  initial begin
    t_reset();
    t_match();
    t_nodst_zero();
    t_full();
    t_order();
    t_empty_remove();
    t_same_cycle_search();
    t_swap();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule